// File: doc/BRIEF.md
# Instruction Decoder with Build-Time Unit Gating

This block turns one 32-bit fixed-length instruction word, together with the address it was fetched from, into the control fields a simple in-order pipeline needs. These are the register indices, a write enable, the immediate already widened to 32 bits, an operation code, the kind of control transfer and its target, and an exception cause. The top six bits select the opcode. The most significant bit splits the opcode space into a register-immediate half (bit clear) and a register-register half (bit set). In many slots both halves carry the same operation, so one ALU code serves both forms.

Four build-time switches state whether the core has a multiplier, a divider, a barrel shifter and a sign extender. When a unit is absent, the opcodes that need it decode as an exception instead of an operation. A core without the barrel shifter can still shift right by one position. For a register-register right shift the amount is only known at run time, so the decoder raises a flag and leaves that check to execution.

The decoder captures its result on a valid strobe. A two-state machine (ST_IDLE, ST_SHOW) marks the cycle in which the registered fields are meaningful. From either state, a cycle with `in_valid` high moves to ST_SHOW and a cycle with it low moves to ST_IDLE. Reset returns the machine to ST_IDLE.

Top module: `insn_decoder`

## Requirements
- R1: Field A is bits 25:21, field B is bits 20:16 and field C is bits 15:11. `rs_a_idx` is always field A. In the register-immediate half the destination is field B. In the register-register half the destination is field C and `rs_b_idx` is field B. Stores, conditional branches and CSR writes report field B as `rs_b_idx` and do not write. CSR reads (opcode 36) write field C.
- R2: The immediate is the low 16 bits sign-extended for add, signed compares, multiply, loads and stores. It is zero-extended for and, or, xor, nor, xnor and the unsigned compares (opcodes 28, 29). It is placed in the upper half for opcodes 24 and 30. Immediate shifts use bits 4:0 zero-extended. Register-register forms report an immediate of 0.
- R3: Conditional branches (opcodes 17 to 21 and 23) report `br_kind` 1 and a target of PC plus the sign-extended low 16 bits times 4.
- R4: Opcodes 56 and 62 report `br_kind` 3 and a target of PC plus the sign-extended bits 25:0 times 4. Opcodes 48 and 54 report `br_kind` 2, the target coming from register field A. Otherwise `br_kind` is 0.
- R5: Calls (opcodes 54 and 62) write register 29 with an immediate equal to PC+4 and the link operation.
- R6: Opcode 43 decodes bits 4:0 = 2 as a breakpoint (`exc_cause` 3) and 7 as a system call (`exc_cause` 4). Any other value is illegal (`exc_cause` 1).
- R7: Opcodes 39, 42, 51 and 53 decode as illegal (`exc_cause` 1).
- R8: With a unit absent, the matching opcodes give `exc_cause` 2: multiply (2, 34), divide and modulo (35, 49), and sign extend (44, 55).
- R9: Without the barrel shifter, left shifts (15, 47) give `exc_cause` 2. Immediate right shifts (0, 5) are legal only with an amount of 1. Register-register right shifts (32, 37) stay legal and raise `need_unit_shift`.
- R10: `exc_valid` is high exactly when `exc_cause` is non-zero. On an exception `wr_en` is 0, `br_kind` is 0 and `alu_op` is OP_NONE.
- R11: A word presented with `in_valid` appears on the outputs in the next cycle with `out_valid` high. `out_valid` is low in any cycle after one without `in_valid`. After reset, `out_valid` and `exc_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word valid this cycle |
| insn | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| out_valid | output | 1 | Decoded fields valid |
| rd_idx | output | 5 | Destination register |
| rs_a_idx | output | 5 | First source register, also the CSR index |
| rs_b_idx | output | 5 | Second source register (0 when unused) |
| wr_en | output | 1 | Destination is written |
| imm | output | 32 | Widened immediate or link value |
| alu_op | output | 6 | Operation code (package enum) |
| br_kind | output | 2 | 0 none, 1 conditional, 2 via register, 3 relative |
| br_target | output | 32 | PC-relative target |
| need_unit_shift | output | 1 | Execution must check the shift amount is 1 |
| exc_valid | output | 1 | Exception raised |
| exc_cause | output | 3 | 0 none, 1 illegal, 2 unit absent, 3 breakpoint, 4 system call |

## Verification
Two copies of the block run side by side on the same word: one with every unit present and one with none. The same opcode must decode to an operation in the first copy and to a unit-absent exception in the second. Immediates with the sign bit set tell sign extension apart from zero extension and from upper-half placement. Branch offsets of minus one and of a positive value expose errors in the shift and sign handling of the target. Shift amounts of 1 and of 3 separate the single-step right shift from an illegal one. The three system-call selector values and the reserved slots are checked one by one. Idle gaps between back-to-back words check when the valid flag drops.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
    localparam int XLEN     = 32;
    localparam int INSN_W   = 32;
    localparam int RIDX_W   = 5;
    localparam int OPC_W    = 6;
    localparam int OP_W     = 6;
    localparam int LINK_REG = 29;

    typedef enum logic [OP_W-1:0] {
        OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR, OP_XNOR,
        OP_SLL, OP_SRL, OP_SRA, OP_MUL, OP_DIVU, OP_MODU, OP_SEXTB, OP_SEXTH,
        OP_CEQ, OP_CNE, OP_CGT, OP_CGE, OP_CGTU, OP_CGEU,
        OP_LDB, OP_LDBU, OP_LDH, OP_LDHU, OP_LDW, OP_STB, OP_STH, OP_STW,
        OP_CSRR, OP_CSRW, OP_LINK
    } alu_op_e;

    typedef enum logic [1:0] {BR_NONE, BR_COND, BR_REG, BR_REL} br_kind_e;

    typedef enum logic [2:0] {
        EXC_NONE, EXC_ILLEGAL, EXC_NOUNIT, EXC_BREAK, EXC_SCALL
    } cause_e;

    typedef enum logic [2:0] {
        IMM_NONE, IMM_SEXT16, IMM_ZEXT16, IMM_HIGH16, IMM_SH5, IMM_LINK
    } imm_kind_e;

    typedef enum logic [1:0] {RD_NONE, RD_B, RD_C, RD_LINK} rd_sel_e;

    typedef enum logic [2:0] {
        NEED_NONE, NEED_MUL, NEED_DIV, NEED_SEXT, NEED_SHL, NEED_SHR
    } unit_e;

    typedef struct packed {
        alu_op_e   op;
        imm_kind_e ik;
        br_kind_e  br;
        rd_sel_e   rd;
        logic      use_b;
        unit_e     need;
        logic      bad;
        logic      brk;
        logic      sys;
    } dec_raw_t;
endpackage

// File: rtl/dec_table.sv
module dec_table
    import isa_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [4:0]       imm5,
    output dec_raw_t         raw
);
    function automatic dec_raw_t f_alu(alu_op_e op, imm_kind_e ik, logic rr, unit_e nd);
        dec_raw_t r;
        r       = '0;
        r.op    = op;
        r.ik    = rr ? IMM_NONE : ik;
        r.rd    = rr ? RD_C : RD_B;
        r.use_b = rr;
        r.need  = nd;
        return r;
    endfunction

    function automatic dec_raw_t f_mem(alu_op_e op, logic store);
        dec_raw_t r;
        r       = '0;
        r.op    = op;
        r.ik    = IMM_SEXT16;
        r.rd    = store ? RD_NONE : RD_B;
        r.use_b = store;
        return r;
    endfunction

    function automatic dec_raw_t f_bcc(alu_op_e op);
        dec_raw_t r;
        r       = '0;
        r.op    = op;
        r.br    = BR_COND;
        r.use_b = 1'b1;
        return r;
    endfunction

    logic rr;
    assign rr = opc[OPC_W-1];

    always_comb begin
        raw = '0;
        unique case (opc)
            6'd0, 6'd32:  raw = f_alu(OP_SRL, IMM_SH5, rr, NEED_SHR);
            6'd1, 6'd33:  raw = f_alu(OP_NOR, IMM_ZEXT16, rr, NEED_NONE);
            6'd2, 6'd34:  raw = f_alu(OP_MUL, IMM_SEXT16, rr, NEED_MUL);
            6'd3:         raw = f_mem(OP_STH, 1'b1);
            6'd4:         raw = f_mem(OP_LDB, 1'b0);
            6'd5, 6'd37:  raw = f_alu(OP_SRA, IMM_SH5, rr, NEED_SHR);
            6'd6, 6'd38:  raw = f_alu(OP_XOR, IMM_ZEXT16, rr, NEED_NONE);
            6'd7:         raw = f_mem(OP_LDH, 1'b0);
            6'd8, 6'd40:  raw = f_alu(OP_AND, IMM_ZEXT16, rr, NEED_NONE);
            6'd9, 6'd41:  raw = f_alu(OP_XNOR, IMM_ZEXT16, rr, NEED_NONE);
            6'd10:        raw = f_mem(OP_LDW, 1'b0);
            6'd11:        raw = f_mem(OP_LDHU, 1'b0);
            6'd12:        raw = f_mem(OP_STB, 1'b1);
            6'd13, 6'd45: raw = f_alu(OP_ADD, IMM_SEXT16, rr, NEED_NONE);
            6'd14, 6'd46: raw = f_alu(OP_OR, IMM_ZEXT16, rr, NEED_NONE);
            6'd15, 6'd47: raw = f_alu(OP_SLL, IMM_SH5, rr, NEED_SHL);
            6'd16:        raw = f_mem(OP_LDBU, 1'b0);
            6'd17:        raw = f_bcc(OP_CEQ);
            6'd18:        raw = f_bcc(OP_CGT);
            6'd19:        raw = f_bcc(OP_CGE);
            6'd20:        raw = f_bcc(OP_CGEU);
            6'd21:        raw = f_bcc(OP_CGTU);
            6'd22:        raw = f_mem(OP_STW, 1'b1);
            6'd23:        raw = f_bcc(OP_CNE);
            6'd24:        raw = f_alu(OP_AND, IMM_HIGH16, 1'b0, NEED_NONE);
            6'd25, 6'd57: raw = f_alu(OP_CEQ, IMM_SEXT16, rr, NEED_NONE);
            6'd26, 6'd58: raw = f_alu(OP_CGT, IMM_SEXT16, rr, NEED_NONE);
            6'd27, 6'd59: raw = f_alu(OP_CGE, IMM_SEXT16, rr, NEED_NONE);
            6'd28, 6'd60: raw = f_alu(OP_CGEU, IMM_ZEXT16, rr, NEED_NONE);
            6'd29, 6'd61: raw = f_alu(OP_CGTU, IMM_ZEXT16, rr, NEED_NONE);
            6'd30:        raw = f_alu(OP_OR, IMM_HIGH16, 1'b0, NEED_NONE);
            6'd31, 6'd63: raw = f_alu(OP_CNE, IMM_SEXT16, rr, NEED_NONE);
            6'd35:        raw = f_alu(OP_DIVU, IMM_NONE, 1'b1, NEED_DIV);
            6'd36:        begin raw.op = OP_CSRR; raw.rd = RD_C; end
            6'd43: begin
                if (imm5 == 5'd2)      raw.brk = 1'b1;
                else if (imm5 == 5'd7) raw.sys = 1'b1;
                else                   raw.bad = 1'b1;
            end
            6'd44: begin raw.op = OP_SEXTB; raw.rd = RD_C; raw.need = NEED_SEXT; end
            6'd48: raw.br = BR_REG;
            6'd49: raw = f_alu(OP_MODU, IMM_NONE, 1'b1, NEED_DIV);
            6'd50: raw = f_alu(OP_SUB, IMM_NONE, 1'b1, NEED_NONE);
            6'd52: begin raw.op = OP_CSRW; raw.use_b = 1'b1; end
            6'd54: begin raw.op = OP_LINK; raw.br = BR_REG; raw.rd = RD_LINK; raw.ik = IMM_LINK; end
            6'd55: begin raw.op = OP_SEXTH; raw.rd = RD_C; raw.need = NEED_SEXT; end
            6'd56: raw.br = BR_REL;
            6'd62: begin raw.op = OP_LINK; raw.br = BR_REL; raw.rd = RD_LINK; raw.ik = IMM_LINK; end
            default: raw.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/dec_gate.sv
module dec_gate
    import isa_dec_pkg::*;
#(
    parameter bit HAS_MUL   = 1'b1,
    parameter bit HAS_DIV   = 1'b1,
    parameter bit HAS_SHIFT = 1'b1,
    parameter bit HAS_SEXT  = 1'b1
) (
    input  logic   bad,
    input  logic   brk,
    input  logic   sys,
    input  unit_e  need,
    input  logic   rr,
    input  logic [4:0] imm5,
    output cause_e cause,
    output logic   unit_shift
);
    always_comb begin
        cause      = EXC_NONE;
        unit_shift = 1'b0;
        if (bad)      cause = EXC_ILLEGAL;
        else if (brk) cause = EXC_BREAK;
        else if (sys) cause = EXC_SCALL;
        else begin
            unique case (need)
                NEED_MUL:  if (!HAS_MUL)   cause = EXC_NOUNIT;
                NEED_DIV:  if (!HAS_DIV)   cause = EXC_NOUNIT;
                NEED_SEXT: if (!HAS_SEXT)  cause = EXC_NOUNIT;
                NEED_SHL:  if (!HAS_SHIFT) cause = EXC_NOUNIT;
                NEED_SHR: begin
                    if (!HAS_SHIFT) begin
                        if (rr)                 unit_shift = 1'b1;
                        else if (imm5 != 5'd1)  cause = EXC_NOUNIT;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dec_imm.sv
module dec_imm
    import isa_dec_pkg::*;
(
    input  imm_kind_e       ik,
    input  br_kind_e        br,
    input  logic [25:0]     fld,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] target
);
    localparam int WORD_SH = 2;
    localparam int INSN_BYTES = INSN_W / 8;

    always_comb begin
        unique case (ik)
            IMM_SEXT16: imm = {{(XLEN-16){fld[15]}}, fld[15:0]};
            IMM_ZEXT16: imm = {{(XLEN-16){1'b0}}, fld[15:0]};
            IMM_HIGH16: imm = {fld[15:0], {(XLEN-16){1'b0}}};
            IMM_SH5:    imm = {{(XLEN-5){1'b0}}, fld[4:0]};
            IMM_LINK:   imm = pc + XLEN'(INSN_BYTES);
            default:    imm = '0;
        endcase
        unique case (br)
            BR_COND: target = pc + ({{(XLEN-16){fld[15]}}, fld[15:0]} << WORD_SH);
            BR_REL:  target = pc + ({{(XLEN-26){fld[25]}}, fld[25:0]} << WORD_SH);
            default: target = '0;
        endcase
    end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import isa_dec_pkg::*;
#(
    parameter bit HAS_MUL   = 1'b1,
    parameter bit HAS_DIV   = 1'b1,
    parameter bit HAS_SHIFT = 1'b1,
    parameter bit HAS_SEXT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   pc,
    output logic              out_valid,
    output logic [RIDX_W-1:0] rd_idx,
    output logic [RIDX_W-1:0] rs_a_idx,
    output logic [RIDX_W-1:0] rs_b_idx,
    output logic              wr_en,
    output logic [XLEN-1:0]   imm,
    output logic [OP_W-1:0]   alu_op,
    output logic [1:0]        br_kind,
    output logic [XLEN-1:0]   br_target,
    output logic              need_unit_shift,
    output logic              exc_valid,
    output logic [2:0]        exc_cause
);
    typedef enum logic {ST_IDLE, ST_SHOW} st_e;

    dec_raw_t        raw;
    cause_e          cause;
    logic            ushift;
    logic [XLEN-1:0] imm_w, tgt_w;
    logic [RIDX_W-1:0] fa, fb, fc, rd_n;
    logic            exc_n;
    st_e             st_q, st_d;

    assign fa = insn[25:21];
    assign fb = insn[20:16];
    assign fc = insn[15:11];

    dec_table u_table (.opc(insn[31:26]), .imm5(insn[4:0]), .raw(raw));

    dec_gate #(.HAS_MUL(HAS_MUL), .HAS_DIV(HAS_DIV), .HAS_SHIFT(HAS_SHIFT), .HAS_SEXT(HAS_SEXT))
    u_gate (.bad(raw.bad), .brk(raw.brk), .sys(raw.sys), .need(raw.need), .rr(insn[31]),
            .imm5(insn[4:0]), .cause(cause), .unit_shift(ushift));

    dec_imm u_imm (.ik(raw.ik), .br(raw.br), .fld(insn[25:0]), .pc(pc), .imm(imm_w), .target(tgt_w));

    always_comb begin
        exc_n = (cause != EXC_NONE);
        unique case (raw.rd)
            RD_B:    rd_n = fb;
            RD_C:    rd_n = fc;
            RD_LINK: rd_n = RIDX_W'(LINK_REG);
            default: rd_n = '0;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: st_d = in_valid ? ST_SHOW : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx <= '0; rs_a_idx <= '0; rs_b_idx <= '0; wr_en <= 1'b0;
            imm <= '0; alu_op <= OP_NONE; br_kind <= BR_NONE; br_target <= '0;
            need_unit_shift <= 1'b0; exc_valid <= 1'b0; exc_cause <= EXC_NONE;
        end else if (in_valid) begin
            rd_idx          <= rd_n;
            rs_a_idx        <= fa;
            rs_b_idx        <= raw.use_b ? fb : '0;
            wr_en           <= (raw.rd != RD_NONE) && !exc_n;
            imm             <= imm_w;
            alu_op          <= exc_n ? OP_NONE : raw.op;
            br_kind         <= exc_n ? BR_NONE : raw.br;
            br_target       <= tgt_w;
            need_unit_shift <= ushift && !exc_n;
            exc_valid       <= exc_n;
            exc_cause       <= cause;
        end
    end

    assign out_valid = (st_q == ST_SHOW);

    assert_latency_R11: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
    assert_idle_R11: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
    assert_exc_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (!wr_en && br_kind == BR_NONE && alu_op == OP_NONE));
    assert_link_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && alu_op == OP_LINK) |-> (wr_en && rd_idx == RIDX_W'(LINK_REG)));
    assert_mul_gate_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (HAS_MUL || alu_op != OP_MUL));
    assert_shl_gate_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (HAS_SHIFT || alu_op != OP_SLL));
endmodule

// File: tb/insn_decoder_bench.sv
`timescale 1ns/1ps
module insn_decoder_bench;
    import isa_dec_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] pc = '0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    logic ov_f, wr_f, nu_f, ev_f, ov_m, wr_m, nu_m, ev_m;
    logic [4:0] rd_f, ra_f, rb_f, rd_m, ra_m, rb_m;
    logic [31:0] im_f, tg_f, im_m, tg_m;
    logic [5:0] op_f, op_m;
    logic [1:0] br_f, br_m;
    logic [2:0] ec_f, ec_m;

    insn_decoder u_insn_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .pc(pc),
        .out_valid(ov_f), .rd_idx(rd_f), .rs_a_idx(ra_f), .rs_b_idx(rb_f), .wr_en(wr_f),
        .imm(im_f), .alu_op(op_f), .br_kind(br_f), .br_target(tg_f),
        .need_unit_shift(nu_f), .exc_valid(ev_f), .exc_cause(ec_f));

    insn_decoder #(.HAS_MUL(1'b0), .HAS_DIV(1'b0), .HAS_SHIFT(1'b0), .HAS_SEXT(1'b0))
    u_insn_decoder_min (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .pc(pc),
        .out_valid(ov_m), .rd_idx(rd_m), .rs_a_idx(ra_m), .rs_b_idx(rb_m), .wr_en(wr_m),
        .imm(im_m), .alu_op(op_m), .br_kind(br_m), .br_target(tg_m),
        .need_unit_shift(nu_m), .exc_valid(ev_m), .exc_cause(ec_m));

    wire [92:0] got_f = {rd_f, ra_f, rb_f, wr_f, im_f, op_f, br_f, tg_f, nu_f, ev_f, ec_f};
    wire [92:0] got_m = {rd_m, ra_m, rb_m, wr_m, im_m, op_m, br_m, tg_m, nu_m, ev_m, ec_m};

    // Behavioural reference: expected outputs from the requirements.
    function automatic logic [92:0] model(input logic [31:0] w, input logic [31:0] p,
                                          input bit fm, input bit fd, input bit fs, input bit fx);
        logic [5:0] opc; logic rr; logic [4:0] a, b, c, rd, rb;
        logic [31:0] s16, z16, imm, tgt, immv; logic wr, nus, alu;
        logic [5:0] op; logic [1:0] br; logic [2:0] cs;
        opc = w[31:26]; rr = w[31]; a = w[25:21]; b = w[20:16]; c = w[15:11];
        s16 = {{16{w[15]}}, w[15:0]}; z16 = {16'h0, w[15:0]};
        rd = 0; rb = 0; imm = 0; tgt = 0; immv = 0; wr = 0; nus = 0; alu = 0;
        op = OP_NONE; br = 0; cs = 0;
        case (opc)
            0, 32:  begin op = OP_SRL;  alu = 1; immv = {27'h0, w[4:0]}; end
            1, 33:  begin op = OP_NOR;  alu = 1; immv = z16; end
            2, 34:  begin op = OP_MUL;  alu = 1; immv = s16; end
            3:      begin op = OP_STH;  rb = b; imm = s16; end
            4:      begin op = OP_LDB;  rd = b; wr = 1; imm = s16; end
            5, 37:  begin op = OP_SRA;  alu = 1; immv = {27'h0, w[4:0]}; end
            6, 38:  begin op = OP_XOR;  alu = 1; immv = z16; end
            7:      begin op = OP_LDH;  rd = b; wr = 1; imm = s16; end
            8, 40:  begin op = OP_AND;  alu = 1; immv = z16; end
            9, 41:  begin op = OP_XNOR; alu = 1; immv = z16; end
            10:     begin op = OP_LDW;  rd = b; wr = 1; imm = s16; end
            11:     begin op = OP_LDHU; rd = b; wr = 1; imm = s16; end
            12:     begin op = OP_STB;  rb = b; imm = s16; end
            13, 45: begin op = OP_ADD;  alu = 1; immv = s16; end
            14, 46: begin op = OP_OR;   alu = 1; immv = z16; end
            15, 47: begin op = OP_SLL;  alu = 1; immv = {27'h0, w[4:0]}; end
            16:     begin op = OP_LDBU; rd = b; wr = 1; imm = s16; end
            17, 18, 19, 20, 21, 23: begin
                case (opc)
                    17: op = OP_CEQ;  18: op = OP_CGT;  19: op = OP_CGE;
                    20: op = OP_CGEU; 21: op = OP_CGTU; default: op = OP_CNE;
                endcase
                rb = b; br = 1; tgt = p + (s16 << 2);
            end
            22:     begin op = OP_STW;  rb = b; imm = s16; end
            24:     begin op = OP_AND;  alu = 1; immv = {w[15:0], 16'h0}; end
            25, 57: begin op = OP_CEQ;  alu = 1; immv = s16; end
            26, 58: begin op = OP_CGT;  alu = 1; immv = s16; end
            27, 59: begin op = OP_CGE;  alu = 1; immv = s16; end
            28, 60: begin op = OP_CGEU; alu = 1; immv = z16; end
            29, 61: begin op = OP_CGTU; alu = 1; immv = z16; end
            30:     begin op = OP_OR;   alu = 1; immv = {w[15:0], 16'h0}; end
            31, 63: begin op = OP_CNE;  alu = 1; immv = s16; end
            35:     begin op = OP_DIVU; alu = 1; end
            36:     begin op = OP_CSRR; rd = c; wr = 1; end
            43:     cs = (w[4:0] == 2) ? 3 : (w[4:0] == 7) ? 4 : 1;
            44:     begin op = OP_SEXTB; rd = c; wr = 1; end
            48:     br = 2;
            49:     begin op = OP_MODU; alu = 1; end
            50:     begin op = OP_SUB;  alu = 1; end
            52:     begin op = OP_CSRW; rb = b; end
            54:     begin op = OP_LINK; br = 2; rd = 29; wr = 1; imm = p + 4; end
            55:     begin op = OP_SEXTH; rd = c; wr = 1; end
            56:     begin br = 3; tgt = p + ({{6{w[25]}}, w[25:0]} << 2); end
            62:     begin op = OP_LINK; br = 3; rd = 29; wr = 1; imm = p + 4;
                          tgt = p + ({{6{w[25]}}, w[25:0]} << 2); end
            default: cs = 1;
        endcase
        if (alu) begin
            wr = 1; rd = rr ? c : b;
            if (rr) rb = b; else imm = immv;
        end
        if (cs == 0) begin
            if (op == OP_MUL && !fm) cs = 2;
            if ((op == OP_DIVU || op == OP_MODU) && !fd) cs = 2;
            if ((op == OP_SEXTB || op == OP_SEXTH) && !fx) cs = 2;
            if (op == OP_SLL && !fs) cs = 2;
            if ((op == OP_SRL || op == OP_SRA) && !fs) begin
                if (rr) nus = 1;
                else if (w[4:0] != 5'd1) cs = 2;
            end
        end
        if (cs != 0) begin wr = 0; br = 0; op = OP_NONE; nus = 0; end
        return {rd, a, rb, wr, imm, op, br, tgt, nus, (cs != 0), cs};
    endfunction

    function automatic logic [31:0] f_rr(int op, int a, int b, int c);
        return {op[5:0], a[4:0], b[4:0], c[4:0], 11'h0};
    endfunction
    function automatic logic [31:0] f_ri(int op, int a, int b, int im);
        return {op[5:0], a[4:0], b[4:0], im[15:0]};
    endfunction
    function automatic logic [31:0] f_j(int op, int im);
        return {op[5:0], im[25:0]};
    endfunction

    bit pv = 1'b0;
    string ptag = "R11";
    logic [92:0] pexp_f, pexp_m;

    task automatic step(input bit v, input logic [31:0] w, input logic [31:0] p, input string tag);
        @(negedge clk);
        total++;
        if (ov_f !== pv || ov_m !== pv) begin
            bad++;
            $display("FAIL %s out_valid: got %b/%b exp %b", ptag, ov_f, ov_m, pv);
        end
        if (pv) begin
            total++;
            if (got_f !== pexp_f) begin
                bad++;
                $display("FAIL %s full-unit: got %h exp %h", ptag, got_f, pexp_f);
            end
            total++;
            if (got_m !== pexp_m) begin
                bad++;
                $display("FAIL %s no-unit: got %h exp %h", ptag, got_m, pexp_m);
            end
        end
        in_valid = v; insn = w; pc = p;
        pv = v; ptag = tag;
        pexp_f = model(w, p, 1, 1, 1, 1);
        pexp_m = model(w, p, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++; // R11 reset state
        if (ov_f !== 1'b0 || ev_f !== 1'b0 || ov_m !== 1'b0 || ev_m !== 1'b0) begin
            bad++;
            $display("FAIL R11 reset: got %b%b%b%b exp 0000", ov_f, ev_f, ov_m, ev_m);
        end
        // R1 operand fields, both halves
        step(1, f_rr(45, 3, 4, 5), 32'h1000, "R1");
        step(1, f_ri(10, 4, 8, 'hFFFC), 32'h1000, "R1");
        step(1, f_ri(22, 4, 8, 'h0010), 32'h1000, "R1");
        step(1, f_rr(36, 6, 0, 9), 32'h1000, "R1");
        step(1, f_rr(52, 6, 11, 0), 32'h1000, "R1");
        // R2 immediate widening
        step(1, f_ri(13, 3, 7, 'h8001), 32'h1000, "R2");
        step(1, f_ri(14, 2, 6, 'h8001), 32'h1000, "R2");
        step(1, f_ri(30, 0, 6, 'h1234), 32'h1000, "R2");
        step(1, f_ri(28, 1, 2, 'hF000), 32'h1000, "R2");
        step(1, f_ri(26, 1, 2, 'hF000), 32'h1000, "R2");
        step(1, f_ri(24, 1, 2, 'h8000), 32'h1000, "R2");
        // R3 conditional branch targets
        step(1, f_ri(17, 1, 2, 'hFFFF), 32'h1000, "R3");
        step(1, f_ri(21, 1, 2, 'h0010), 32'h1000, "R3");
        step(1, f_ri(23, 5, 6, 'h8000), 32'h4000, "R3");
        // R4 unconditional transfers
        step(1, f_j(56, 'h3FFFFFF), 32'h2000, "R4");
        step(1, f_j(56, 'h100), 32'h2000, "R4");
        step(1, f_rr(48, 9, 0, 0), 32'h2000, "R4");
        // R5 calls
        step(1, f_rr(54, 7, 0, 0), 32'h0300, "R5");
        step(1, f_j(62, 5), 32'h0100, "R5");
        // R6 system-call selector
        step(1, f_ri(43, 0, 0, 2), 32'h1000, "R6");
        step(1, f_ri(43, 0, 0, 7), 32'h1000, "R6");
        step(1, f_ri(43, 0, 0, 5), 32'h1000, "R6");
        // R7 reserved slots, R10 exception quieting
        step(1, f_rr(39, 1, 2, 3), 32'h1000, "R7");
        step(1, f_rr(42, 1, 2, 3), 32'h1000, "R7");
        step(1, f_rr(51, 1, 2, 3), 32'h1000, "R10");
        step(1, f_rr(53, 1, 2, 3), 32'h1000, "R7");
        // R8 unit gating
        step(1, f_ri(2, 1, 2, 'hFFFE), 32'h1000, "R8");
        step(1, f_rr(34, 1, 2, 3), 32'h1000, "R8");
        step(1, f_rr(35, 1, 2, 3), 32'h1000, "R8");
        step(1, f_rr(49, 1, 2, 3), 32'h1000, "R8");
        step(1, f_rr(44, 1, 0, 3), 32'h1000, "R8");
        step(1, f_rr(55, 1, 0, 3), 32'h1000, "R8");
        // R9 shifter gating
        step(1, f_ri(15, 1, 2, 4), 32'h1000, "R9");
        step(1, f_rr(47, 1, 2, 3), 32'h1000, "R9");
        step(1, f_ri(0, 1, 2, 1), 32'h1000, "R9");
        step(1, f_ri(5, 1, 2, 3), 32'h1000, "R9");
        step(1, f_ri(5, 1, 2, 1), 32'h1000, "R9");
        step(1, f_rr(32, 1, 2, 3), 32'h1000, "R9");
        step(1, f_rr(37, 1, 2, 3), 32'h1000, "R9");
        // R11 idle gaps and restart
        step(0, 32'h0, 32'h0, "R11");
        step(0, 32'h0, 32'h0, "R11");
        step(1, f_rr(50, 8, 9, 10), 32'h1000, "R11");
        step(0, 32'h0, 32'h0, "R11");
        step(0, 32'h0, 32'h0, "R11");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule